// File: doc/BRIEF.md
# Interrupt Recognition and Acknowledge Unit

This unit sits next to a small CPU sequencer and decides, at each instruction boundary, whether an interrupt is taken. The sequencer raises `boundary_i` for one clock at the end of every instruction, and also after every completed element of a block move. Two request sources are handled. The first is a non-maskable request that arrives asynchronously. It is recognised on its rising edge and kept pending until serviced. The second is a level-sensitive maskable request that is gated by an interrupt-enable bit in a flags register owned by the unit.

A taken non-maskable request produces a fixed vector type at once. A taken maskable request runs two acknowledge bus cycles back to back, and the type byte is read from the data bus in the second cycle only. In both cases the unit clears the enable bit and presents the flags value from before the clear, so the sequencer can stack it. The unit then pulses `vec_valid_o` with the type number and the vector table address, which is the type times four. The sequencer restores or sets the flags through `flags_wr_i`.

Top module: `irq_ack_unit`

## Requirements
- R1: After reset the acknowledge strobe, `ack_second_o`, `busy_o` and `vec_valid_o` are low, and `flags_o` equals the reset flags value (0x00 by default).
- R2: The non-maskable input passes through a two-flop synchronizer and counts as an edge only once the synchronized level has been high for NMI_MIN (3) consecutive clocks. Shorter pulses are ignored, and a long high level gives one request only.
- R3: A pending non-maskable request is serviced only at a clock where `boundary_i` is high and the unit is idle. Servicing runs no acknowledge cycles and pulses `vec_valid_o` on the next cycle with type 2.
- R4: When both requests are eligible at the same boundary, the non-maskable request is taken.
- R5: The maskable request is taken only if `intr_i` was high at the rising edge just before the boundary edge, and flags bit IE_BIT (bit 5) is 1.
- R6: Any acceptance clears flags bit 5. `saved_flags_o` then holds the flags value from before that clear.
- R7: A maskable acceptance runs two consecutive acknowledge cycles of ACK_CYC (4) clocks each. In each cycle the strobe is high for the first ACK_CYC-1 clocks and low for the last. `ack_second_o` is high during the second cycle. `busy_o` stays high throughout, and boundaries that occur while busy are ignored.
- R8: The type byte is sampled from `ack_data_i` only in the last strobe-high clock of the second cycle. `vec_valid_o` pulses on the clock after the second cycle ends.
- R9: `vec_addr_o` is `vec_type_o` shifted left by two bits (10 bits wide), so type 2 gives 0x008 and type 0x4B gives 0x12C.
- R10: A new non-maskable edge that arrives after an earlier one has been serviced sets the request again and leads to another service.
- R11: A maskable input that is held high is taken again at a later boundary once bit 5 has been set again.
- R12: `flags_wr_i` loads `flags_wdata_i` into the flags, except at an acceptance edge, where the acceptance takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Asynchronous non-maskable request |
| intr_i | input | 1 | Level-sensitive maskable request |
| boundary_i | input | 1 | Instruction or block-element boundary strobe |
| flags_wr_i | input | 1 | Load flags from flags_wdata_i |
| flags_wdata_i | input | 8 | Flags value to load |
| ack_data_i | input | 8 | Data bus from the interrupt controller |
| ack_strobe_o | output | 1 | Acknowledge strobe |
| ack_second_o | output | 1 | High during the second acknowledge cycle |
| busy_o | output | 1 | Acknowledge sequence in progress |
| flags_o | output | 8 | Current flags |
| saved_flags_o | output | 8 | Flags from before the last acceptance |
| vec_valid_o | output | 1 | One-cycle vector pulse |
| vec_type_o | output | 8 | Interrupt type number |
| vec_addr_o | output | 10 | Vector table address |

## Verification
The non-maskable input is driven with a two-clock pulse that must be ignored, with long pulses, with a level held across several boundaries, and with a second rising edge after a service. Together these separate correct edge qualification from level sensing and from losing a re-arm. The maskable input is driven in three ways: it rises in the boundary cycle itself, it drops one cycle before the boundary, or it stays high across a re-enable. These patterns pin down the sampling cycle and the enable gating. Both inputs are also raised together, and the acknowledge data bus carries a decoy value during the first cycle, so that a wrong priority or a capture from the wrong cycle shows up. Boundary strobes issued while busy, and a flags write on an acceptance edge, test the precedence rules.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_FIRST  = 2'd1,
        ACK_SECOND = 2'd2
    } ack_phase_e;

endpackage

// File: rtl/irq_nmi_detect.sv
module irq_nmi_detect #(
    parameter int NMI_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_raw_i,
    input  logic take_i,
    output logic pend_o
);
    localparam int RUN_W = $clog2(NMI_MIN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(NMI_MIN);
    localparam logic [RUN_W-1:0] RUN_HIT = RUN_W'(NMI_MIN - 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic [RUN_W-1:0] run;
        logic             pend;
    } det_t;

    det_t q, d;
    logic hit;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], nmi_raw_i};
        hit    = q.sync[1] && (q.run == RUN_HIT);
        if (!q.sync[1]) begin
            d.run = '0;
        end else if (q.run != RUN_MAX) begin
            d.run = q.run + 1'b1;
        end
        d.pend = (q.pend && !take_i) || hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pend_o = q.pend;
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int ACK_CYC = 4,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] ack_data_i,
    output logic              strobe_o,
    output logic              second_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] type_o
);
    localparam int CNT_W = (ACK_CYC > 2) ? $clog2(ACK_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(ACK_CYC - 1);
    localparam logic [CNT_W-1:0] CAP_AT = CNT_W'(ACK_CYC - 2);

    typedef struct packed {
        ack_phase_e        ph;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] cap;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        unique case (q.ph)
            ACK_IDLE: begin
                if (start_i) begin
                    d.ph  = ACK_FIRST;
                    d.cnt = '0;
                end
            end
            ACK_FIRST: begin
                if (q.cnt == LAST) begin
                    d.ph  = ACK_SECOND;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ACK_SECOND: begin
                if (q.cnt == CAP_AT) begin
                    d.cap = ack_data_i;
                end
                if (q.cnt == LAST) begin
                    d.ph   = ACK_IDLE;
                    d.cnt  = '0;
                    done_o = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.ph  = ACK_IDLE;
                d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{ph: ACK_IDLE, cnt: '0, cap: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.ph != ACK_IDLE);
    assign second_o = (q.ph == ACK_SECOND);
    assign strobe_o = busy_o && (q.cnt != LAST);
    assign type_o   = q.cap;
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
    parameter int              DATA_W      = 8,
    parameter int              FLAG_W      = 8,
    parameter int              IE_BIT      = 5,
    parameter int              ACK_CYC     = 4,
    parameter int              NMI_MIN     = 3,
    parameter logic [DATA_W-1:0] NMI_TYPE  = 8'd2,
    parameter logic [FLAG_W-1:0] RESET_FLAGS = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nmi_i,
    input  logic                intr_i,
    input  logic                boundary_i,
    input  logic                flags_wr_i,
    input  logic [FLAG_W-1:0]   flags_wdata_i,
    input  logic [DATA_W-1:0]   ack_data_i,
    output logic                ack_strobe_o,
    output logic                ack_second_o,
    output logic                busy_o,
    output logic [FLAG_W-1:0]   flags_o,
    output logic [FLAG_W-1:0]   saved_flags_o,
    output logic                vec_valid_o,
    output logic [DATA_W-1:0]   vec_type_o,
    output logic [DATA_W+1:0]   vec_addr_o
);
    typedef struct packed {
        logic              intr;
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] saved;
        logic              vv;
        logic [DATA_W-1:0] vtype;
    } top_t;

    top_t q, d;

    logic              nmi_pend;
    logic              take_nmi;
    logic              take_int;
    logic              seq_busy;
    logic              seq_done;
    logic [DATA_W-1:0] seq_type;

    irq_nmi_detect #(
        .NMI_MIN (NMI_MIN)
    ) u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_raw_i (nmi_i),
        .take_i    (take_nmi),
        .pend_o    (nmi_pend)
    );

    irq_ack_seq #(
        .ACK_CYC (ACK_CYC),
        .DATA_W  (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (take_int),
        .ack_data_i (ack_data_i),
        .strobe_o   (ack_strobe_o),
        .second_o   (ack_second_o),
        .busy_o     (seq_busy),
        .done_o     (seq_done),
        .type_o     (seq_type)
    );

    always_comb begin
        take_nmi = boundary_i && !seq_busy && nmi_pend;
        take_int = boundary_i && !seq_busy && !nmi_pend && q.intr && q.flags[IE_BIT];

        d      = q;
        d.intr = intr_i;
        d.vv   = 1'b0;
        if (seq_done) begin
            d.vv    = 1'b1;
            d.vtype = seq_type;
        end
        if (take_nmi) begin
            d.vv    = 1'b1;
            d.vtype = NMI_TYPE;
        end
        if (take_nmi || take_int) begin
            d.saved         = q.flags;
            d.flags[IE_BIT] = 1'b0;
        end else if (flags_wr_i) begin
            d.flags = flags_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{intr: 1'b0, flags: RESET_FLAGS, saved: '0, vv: 1'b0, vtype: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o        = seq_busy;
    assign flags_o       = q.flags;
    assign saved_flags_o = q.saved;
    assign vec_valid_o   = q.vv;
    assign vec_type_o    = q.vtype;
    assign vec_addr_o    = {q.vtype, 2'b00};
endmodule

// File: rtl/irq_ack_unit_chk.sv
module irq_ack_unit_chk #(
    parameter int                FLAG_W   = 8,
    parameter int                DATA_W   = 8,
    parameter int                IE_BIT   = 5,
    parameter logic [DATA_W-1:0] NMI_TYPE = 8'd2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary_i,
    input logic              ack_strobe_o,
    input logic              ack_second_o,
    input logic              busy_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic              vec_valid_o,
    input logic [DATA_W-1:0] vec_type_o
);
    // R7
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_strobe_o |-> busy_o);

    // R7
    second_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_second_o |-> busy_o);

    // R5
    start_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(boundary_i));

    // R6
    start_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !flags_o[IE_BIT]);

    // R8
    done_gives_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> vec_valid_o);

    // R3
    idle_vector_is_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && !$past(busy_o)) |-> (vec_type_o == NMI_TYPE));
endmodule

bind irq_ack_unit irq_ack_unit_chk #(
    .FLAG_W   (FLAG_W),
    .DATA_W   (DATA_W),
    .IE_BIT   (IE_BIT),
    .NMI_TYPE (NMI_TYPE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .boundary_i   (boundary_i),
    .ack_strobe_o (ack_strobe_o),
    .ack_second_o (ack_second_o),
    .busy_o       (busy_o),
    .flags_o      (flags_o),
    .vec_valid_o  (vec_valid_o),
    .vec_type_o   (vec_type_o)
);

// File: tb/irq_ack_unit_bench.sv
module irq_ack_unit_bench;
    localparam int AC   = 4;
    localparam int NMIN = 3;
    localparam int IE   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi = 1'b0, intr = 1'b0, boundary = 1'b0, fwr = 1'b0;
    logic [7:0] fwdata = 8'h00, ack_data = 8'h00;
    logic       strobe, second, busy, vvalid;
    logic [7:0] flags, saved, vtype;
    logic [9:0] vaddr;

    irq_ack_unit u_irq_ack_unit (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .intr_i(intr), .boundary_i(boundary),
        .flags_wr_i(fwr), .flags_wdata_i(fwdata), .ack_data_i(ack_data),
        .ack_strobe_o(strobe), .ack_second_o(second), .busy_o(busy),
        .flags_o(flags), .saved_flags_o(saved), .vec_valid_o(vvalid),
        .vec_type_o(vtype), .vec_addr_o(vaddr)
    );

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit         m_s0, m_s1, m_pend, m_intr, m_vv;
    int         m_run, m_phase;
    logic [7:0] m_flags, m_saved, m_vtype, m_cap;
    logic [7:0] cur_type = 8'h4B;
    bit         t_set, t_nmi, t_int;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s0 = 0; m_s1 = 0; m_pend = 0; m_intr = 0; m_vv = 0;
            m_run = 0; m_phase = 0;
            m_flags = 8'h00; m_saved = 8'h00; m_vtype = 8'h00; m_cap = 8'h00;
        end else begin
            t_set = m_s1 && (m_run == NMIN - 1);
            t_nmi = boundary && (m_phase == 0) && m_pend;
            t_int = boundary && (m_phase == 0) && !m_pend && m_intr && m_flags[IE];
            m_vv = 0;
            if (m_phase != 0) begin
                if (m_phase == 2 * AC) begin
                    m_phase = 0; m_vv = 1; m_vtype = m_cap;
                end else begin
                    if (m_phase == 2 * AC - 1) m_cap = ack_data;
                    m_phase++;
                end
            end
            if (t_nmi) begin m_vv = 1; m_vtype = 8'd2; end
            if (t_nmi || t_int) begin
                m_saved = m_flags; m_flags[IE] = 1'b0;
                if (t_int) m_phase = 1;
            end else if (fwr) m_flags = fwdata;
            m_pend = (m_pend && !t_nmi) || t_set;
            if (m_s1) m_run = (m_run < NMIN) ? m_run + 1 : m_run; else m_run = 0;
            m_s1 = m_s0; m_s0 = nmi;
            m_intr = intr;
        end
    end

    // controller data bus: decoy in the first cycle, real type in the second
    always @(negedge clk) ack_data <= (m_phase > AC) ? cur_type : 8'hEE;

    // per-clock comparison and event counters
    int n_nmi_vec = 0, n_int_vec = 0, n_rise = 0;
    logic prev_strobe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(strobe == (m_phase != 0 && ((m_phase - 1) % AC) != AC - 1), "R7 strobe", 32'(strobe), 32'(m_phase));
            chk(second == (m_phase > AC), "R7 second", 32'(second), 32'(m_phase > AC));
            chk(busy == (m_phase != 0), "R7 busy", 32'(busy), 32'(m_phase != 0));
            chk(flags == m_flags, "R6 flags", 32'(flags), 32'(m_flags));
            chk(saved == m_saved, "R6 saved", 32'(saved), 32'(m_saved));
            chk(vvalid == m_vv, "R8 vec_valid", 32'(vvalid), 32'(m_vv));
            chk(vtype == m_vtype, "R8 vec_type", 32'(vtype), 32'(m_vtype));
            chk(vaddr == {m_vtype, 2'b00}, "R9 vec_addr", 32'(vaddr), 32'({m_vtype, 2'b00}));
            if (vvalid && vtype == 8'd2) n_nmi_vec++;
            if (vvalid && vtype != 8'd2) n_int_vec++;
            if (strobe && !prev_strobe) n_rise++;
            prev_strobe = strobe;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic bnd();
        boundary = 1'b1; tick(1); boundary = 1'b0;
    endtask
    task automatic nmi_pulse(input int n);
        nmi = 1'b1; tick(n); nmi = 1'b0;
    endtask
    task automatic wr_flags(input logic [7:0] v);
        fwr = 1'b1; fwdata = v; tick(1); fwr = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R7 watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        int b_nmi, b_int, b_rise;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(!strobe && !second && !busy && !vvalid, "R1 reset outputs", {busy, strobe, vvalid}, 0);
        chk(flags == 8'h00, "R1 reset flags", flags, 8'h00);

        // R2 short pulse ignored
        nmi_pulse(2); tick(5); bnd(); tick(4);
        chk(n_nmi_vec == 0, "R2 short pulse", n_nmi_vec, 0);

        // R2/R3/R9 long level gives one service, no ack cycles
        nmi_pulse(12); tick(2); bnd(); tick(3); bnd(); tick(4);
        chk(n_nmi_vec == 1, "R2 one per level", n_nmi_vec, 1);
        chk(n_rise == 0, "R3 no ack cycles", n_rise, 0);
        chk(vaddr == 10'h008, "R9 nmi address", vaddr, 10'h008);

        // R10 new edge after service
        tick(2); nmi_pulse(5); tick(4); bnd(); tick(4);
        chk(n_nmi_vec == 2, "R10 re-armed", n_nmi_vec, 2);

        // R4/R6 priority, flags saved and cleared
        wr_flags(8'h35); intr = 1'b1;
        nmi_pulse(5); tick(4); bnd(); tick(4);
        chk(n_nmi_vec == 3 && n_int_vec == 0, "R4 nmi first", n_int_vec, 0);
        chk(flags == 8'h15, "R6 ie cleared", flags, 8'h15);
        chk(saved == 8'h35, "R6 saved flags", saved, 8'h35);
        bnd(); tick(12);
        chk(n_int_vec == 0, "R5 masked", n_int_vec, 0);

        // R7/R8/R9 maskable acceptance with double acknowledge
        wr_flags(8'h20); tick(1); bnd(); tick(12);
        chk(n_int_vec == 1, "R8 vector pulse", n_int_vec, 1);
        chk(n_rise == 2, "R7 two ack cycles", n_rise, 2);
        chk(vtype == 8'h4B, "R8 second-cycle byte", vtype, 8'h4B);
        chk(vaddr == 10'h12C, "R9 int address", vaddr, 10'h12C);

        // R11 held level taken again after re-enable
        cur_type = 8'h91;
        bnd(); tick(12);
        chk(n_int_vec == 1, "R11 blocked while disabled", n_int_vec, 1);
        wr_flags(8'h20); bnd(); tick(12);
        chk(n_int_vec == 2, "R11 taken again", n_int_vec, 2);
        chk(vtype == 8'h91, "R11 type", vtype, 8'h91);
        intr = 1'b0;

        // R5 sampling cycle
        wr_flags(8'h20); tick(2);
        intr = 1'b1; boundary = 1'b1; tick(1); intr = 1'b0; boundary = 1'b0; tick(12);
        chk(n_int_vec == 2, "R5 rise in boundary cycle", n_int_vec, 2);
        intr = 1'b1; tick(1); intr = 1'b0; tick(1); bnd(); tick(12);
        chk(n_int_vec == 2, "R5 dropped before boundary", n_int_vec, 2);

        // R7 boundary ignored while busy, R3 nmi waits for idle
        intr = 1'b1; tick(1); bnd(); intr = 1'b0;
        b_nmi = n_nmi_vec;
        nmi_pulse(5); bnd(); tick(8);
        chk(n_nmi_vec == b_nmi, "R7 boundary while busy", n_nmi_vec, b_nmi);
        chk(n_int_vec == 3, "R7 sequence completed", n_int_vec, 3);
        bnd(); tick(3);
        chk(n_nmi_vec == b_nmi + 1, "R3 served when idle", n_nmi_vec, b_nmi + 1);

        // R12 flags write vs acceptance
        wr_flags(8'h20); tick(1);
        chk(flags == 8'h20, "R12 flags load", flags, 8'h20);
        nmi_pulse(5); tick(4);
        fwr = 1'b1; fwdata = 8'hFF; boundary = 1'b1; tick(1);
        fwr = 1'b0; boundary = 1'b0; tick(2);
        chk(flags == 8'h00, "R12 acceptance wins", flags, 8'h00);
        chk(saved == 8'h20, "R12 saved", saved, 8'h20);

        b_int = n_int_vec; b_rise = n_rise;
        tick(4);
        chk(n_int_vec == b_int && n_rise == b_rise, "R7 quiet tail", n_rise, b_rise);
        summary();
    end
endmodule